// File: doc/BRIEF.md
# Timer Register Bank

This block is the software-visible register file of a multi-mode counter/timer. A byte-wide write port and a word-wide read port share one byte address inside a 256-byte window. The block turns them into the control, status, compare, mode and divider settings that drive the counter core. Every register accepts writes only in the byte lanes and bits that carry a field. The other bits keep their value. The bus is big-endian: byte offset 0 of a word holds bits 31:24 and offset 3 holds bits 7:0.

The core sends single-cycle status-set pulses and its live count value. Software reads the count back through a read-only word. Writing the low byte of the status word clears every status bit. When that write removes at least one pending bit, the block pulses a strobe so that the interrupt line can be dropped. A control write that leaves the run bit low and the count-reset bit high produces a one-cycle counter-clear strobe toward the core.

Top module: `tmr_regbank`

## Requirements
- R1: After reset, all register fields and strobes are zero, both compare registers hold 0x00FFFFFF and `bus_rdata` is zero.
- R2: Compare A (byte address 0x08) and compare B (0x0C) are 24 bits wide. Byte offsets 1, 2 and 3 write bits 23:16, 15:8 and 7:0. A write at offset 0 is ignored.
- R3: The control word (0x00) takes writes only at offset 3 (bits 7:0), and bit 4 always reads zero. The fields are: run at bit 7, divider enable at bit 6, count reset at bit 5, clock select at bit 2 and mode at bits 1:0. Each field appears on its own output.
- R4: `cnt_clear_o` is high for exactly the one cycle after a control write at offset 3 whose data has bit 7 = 0 and bit 5 = 1. It stays low after any other write.
- R5: Status word 0x04 carries four bits: interval at bit 0, pulse A at bit 1, pulse B at bit 2 and watchdog at bit 3. A `stat_set_i` pulse sets its bit, and the bit stays set. A write at offset 3 (address 0x07) clears all four bits, but a set pulse in the same cycle wins for its own bit. Writes at offsets 0 to 2 are ignored.
- R6: `irq_clear_o` is high for the one cycle after a status clear write, and only if at least one status bit was set before that write.
- R7: The interval mode word (0x10) holds interrupt enable at bit 15, written from data bit 7 at offset 2. It holds zero-clear enable at bit 0, written from data bit 0 at offset 3.
- R8: The pulse mode word (0x30) holds B interrupt enable at bit 15 and A interrupt enable at bit 14, both written at offset 2 from data bits 7 and 6. It holds the flip-flop initial value at bit 0, written at offset 3.
- R9: The watchdog word (0x40) holds interrupt enable at bit 15, written at offset 2. It holds disable at bit 7 and clear at bit 0, both written at offset 3.
- R10: The divider word (0x20) keeps bits 2:0, written at offset 3. All its other bits read zero.
- R11: The count readback word (0xF0) reads {8'h00, `cnt_value_i`}. Writes to it change nothing.
- R12: Reads of word addresses outside the nine mapped words return zero. Writes to them change no register and no output.
- R13: `bus_rdata` is loaded on the clock edge that samples `bus_rd` high. It holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address in the window |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Word read strobe |
| bus_rdata | output | 32 | Registered read word |
| cnt_value_i | input | 24 | Live count from the core |
| stat_set_i | input | 4 | Status-set pulses from the core |
| ctl_run_o | output | 1 | Run bit |
| ctl_div_en_o | output | 1 | Divider enable |
| ctl_cnt_rst_o | output | 1 | Count-reset bit |
| ctl_ext_clk_o | output | 1 | Clock select |
| ctl_mode_o | output | 2 | Mode |
| cmp_a_o | output | 24 | Compare A |
| cmp_b_o | output | 24 | Compare B |
| div_sel_o | output | 3 | Divider selection |
| ivl_irq_en_o | output | 1 | Interval interrupt enable |
| ivl_zero_clr_o | output | 1 | Interval zero-clear enable |
| pls_a_irq_en_o | output | 1 | Pulse A interrupt enable |
| pls_b_irq_en_o | output | 1 | Pulse B interrupt enable |
| pls_ff_init_o | output | 1 | Flip-flop initial value |
| wdg_irq_en_o | output | 1 | Watchdog interrupt enable |
| wdg_disable_o | output | 1 | Watchdog disable |
| wdg_clear_o | output | 1 | Watchdog clear |
| cnt_clear_o | output | 1 | Counter-clear strobe |
| irq_clear_o | output | 1 | Interrupt-deassert strobe |

## Verification
The assertions check, on every cycle, that each strobe has a cause in the previous cycle. They also check that status bits stay set until a clear write, that a clear write with no set pulse empties the status, that reads of unmapped words return zero, that read data holds between reads, and that writes to the readback word leave the settings alone. Only the bench's sweeps can show the exact bit masks and big-endian lane placement of every register. The bench sweeps every word and every lane with several data patterns. The same holds for the set-beats-clear ordering and for the readback of the live count.

// File: rtl/tmr_regbank_pkg.sv
// Shared constants of the timer register bank: register indices, word
// addresses and per-register write masks / reset values.
// Assumes 32-bit words addressed by byte in a 256-byte window.
package tmr_regbank_pkg;

    localparam int NREG     = 9;
    localparam int RI_CTRL  = 0;
    localparam int RI_STAT  = 1;
    localparam int RI_CMPA  = 2;
    localparam int RI_CMPB  = 3;
    localparam int RI_IVL   = 4;
    localparam int RI_DIV   = 5;
    localparam int RI_PLS   = 6;
    localparam int RI_WDG   = 7;
    localparam int RI_CNT   = 8;

    // Word number (byte address / 4) of each register index
    function automatic int word_of(input int idx);
        case (idx)
            RI_CTRL: return 0;
            RI_STAT: return 1;
            RI_CMPA: return 2;
            RI_CMPB: return 3;
            RI_IVL:  return 4;
            RI_DIV:  return 8;
            RI_PLS:  return 12;
            RI_WDG:  return 16;
            default: return 60;
        endcase
    endfunction

    // Writable bits of each register
    function automatic logic [31:0] wmask_of(input int idx, input int cmp_w, input int div_w);
        logic [63:0] cmask;
        logic [63:0] dmask;
        cmask = (64'h1 << cmp_w) - 64'h1;
        dmask = (64'h1 << div_w) - 64'h1;
        case (idx)
            RI_CTRL: return 32'h0000_00EF;
            RI_CMPA: return cmask[31:0];
            RI_CMPB: return cmask[31:0];
            RI_IVL:  return 32'h0000_8001;
            RI_DIV:  return dmask[31:0];
            RI_PLS:  return 32'h0000_C001;
            RI_WDG:  return 32'h0000_8081;
            default: return 32'h0;
        endcase
    endfunction

    // Reset value of each register
    function automatic logic [31:0] rstval_of(input int idx, input int cmp_w);
        logic [63:0] cmask;
        cmask = (64'h1 << cmp_w) - 64'h1;
        if (idx == RI_CMPA || idx == RI_CMPB)
            return cmask[31:0];
        return 32'h0;
    endfunction

endpackage

// File: rtl/tmr_addr_decode.sv
// Address decoder: turns a byte address into a one-hot register select
// and a big-endian byte-lane write strobe (offset 3 -> lane 0, bits 7:0).
// Assumes ADDR_W >= 3 and word numbers that fit in ADDR_W-2 bits.
module tmr_addr_decode
    import tmr_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [NREG-1:0]   word_sel,
    output logic [3:0]        lane_we
);
    localparam int WORD_W = ADDR_W - 2;

    // One comparator per mapped register
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        localparam logic [WORD_W-1:0] WNUM = WORD_W'(word_of(i));
        assign word_sel[i] = (addr[ADDR_W-1:2] == WNUM);
    end

    // Big-endian lane strobe: lane index is the inverse of the byte offset
    always_comb begin
        lane_we = '0;
        if (wr)
            lane_we[~addr[1:0]] = 1'b1;
    end
endmodule

// File: rtl/tmr_masked_reg.sv
// One 32-bit register written a byte at a time; only WMASK bits take the
// write data, every other bit keeps its reset value.
// Assumes lane_we is already gated by the bus write strobe.
module tmr_masked_reg #(
    parameter logic [31:0] WMASK = 32'hFFFF_FFFF,
    parameter logic [31:0] RSTV  = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic [3:0]  lane_we,
    input  logic [7:0]  wbyte,
    output logic [31:0] q
);
    for (genvar l = 0; l < 4; l++) begin : g_lane
        localparam logic [7:0] M = WMASK[l*8 +: 8];
        localparam logic [7:0] R = RSTV[l*8 +: 8];
        logic [7:0] lane_q;

        // Merge the write byte into the writable bits of this lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= R;
            else if (sel && lane_we[l])
                lane_q <= (lane_q & ~M) | (wbyte & M);
        end

        assign q[l*8 +: 8] = lane_q;
    end
endmodule

// File: rtl/tmr_status_reg.sv
// Sticky status bits set by core pulses and cleared as a whole by a
// software write; raises a one-cycle strobe if the clear removed anything.
// Assumes set pulses and the clear are sampled on the same clock.
module tmr_status_reg #(
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] set_i,
    output logic [STAT_W-1:0] q,
    output logic              irq_clear_o
);
    // Latch set pulses; a clear write keeps only same-cycle set pulses
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (clr_we)
            q <= set_i;
        else
            q <= q | set_i;
    end

    // Deassert strobe when a clear hit a non-empty status
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_clear_o <= 1'b0;
        else
            irq_clear_o <= clr_we && (|q);
    end
endmodule

// File: rtl/tmr_read_port.sv
// Registered read multiplexer: on a read strobe loads the selected word,
// or zero when no register is selected; holds otherwise.
// Assumes word_sel is one-hot or zero.
module tmr_read_port #(
    parameter int NSEL = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd,
    input  logic [NSEL-1:0] word_sel,
    input  logic [31:0]     vals [NSEL],
    output logic [31:0]     rdata
);
    logic [31:0] mux;

    // AND-OR select of the addressed word
    always_comb begin
        mux = '0;
        for (int i = 0; i < NSEL; i++)
            mux = mux | (word_sel[i] ? vals[i] : 32'h0);
    end

    // Load on read, hold between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd)
            rdata <= mux;
    end
endmodule

// File: rtl/tmr_regbank.sv
// Register bank of a multi-mode timer: decodes a byte-write / word-read
// bus, holds masked settings, sticky status and count readback, and emits
// counter-clear and interrupt-deassert strobes.
// Assumes synchronous active-low reset and a 2^ADDR_W byte window.
module tmr_regbank
    import tmr_regbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CMP_W  = 24,
    parameter int DIV_W  = 3,
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [CMP_W-1:0]  cnt_value_i,
    input  logic [STAT_W-1:0] stat_set_i,
    output logic              ctl_run_o,
    output logic              ctl_div_en_o,
    output logic              ctl_cnt_rst_o,
    output logic              ctl_ext_clk_o,
    output logic [1:0]        ctl_mode_o,
    output logic [CMP_W-1:0]  cmp_a_o,
    output logic [CMP_W-1:0]  cmp_b_o,
    output logic [DIV_W-1:0]  div_sel_o,
    output logic              ivl_irq_en_o,
    output logic              ivl_zero_clr_o,
    output logic              pls_a_irq_en_o,
    output logic              pls_b_irq_en_o,
    output logic              pls_ff_init_o,
    output logic              wdg_irq_en_o,
    output logic              wdg_disable_o,
    output logic              wdg_clear_o,
    output logic              cnt_clear_o,
    output logic              irq_clear_o
);
    logic [NREG-1:0]   word_sel;
    logic [3:0]        lane_we;
    logic [31:0]       vals [NREG];
    logic [STAT_W-1:0] stat_q;
    logic              stat_clr_we;

    tmr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .word_sel (word_sel),
        .lane_we  (lane_we)
    );

    // One storage element per register index; status and readback are special
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == RI_STAT) begin : g_stat
            assign vals[i] = 32'(stat_q);
        end else if (i == RI_CNT) begin : g_cnt
            assign vals[i] = 32'(cnt_value_i);
        end else begin : g_rw
            tmr_masked_reg #(
                .WMASK (wmask_of(i, CMP_W, DIV_W)),
                .RSTV  (rstval_of(i, CMP_W))
            ) u_reg (
                .clk     (clk),
                .rst_n   (rst_n),
                .sel     (word_sel[i]),
                .lane_we (lane_we),
                .wbyte   (bus_wdata),
                .q       (vals[i])
            );
        end
    end

    assign stat_clr_we = word_sel[RI_STAT] && lane_we[0];

    tmr_status_reg #(.STAT_W(STAT_W)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_we      (stat_clr_we),
        .set_i       (stat_set_i),
        .q           (stat_q),
        .irq_clear_o (irq_clear_o)
    );

    // Counter-clear strobe: control write with run low and count reset high
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_clear_o <= 1'b0;
        else
            cnt_clear_o <= word_sel[RI_CTRL] && lane_we[0] && !bus_wdata[7] && bus_wdata[5];
    end

    tmr_read_port #(.NSEL(NREG)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .word_sel (word_sel),
        .vals     (vals),
        .rdata    (bus_rdata)
    );

    // Field breakout toward the counter core
    assign ctl_run_o      = vals[RI_CTRL][7];
    assign ctl_div_en_o   = vals[RI_CTRL][6];
    assign ctl_cnt_rst_o  = vals[RI_CTRL][5];
    assign ctl_ext_clk_o  = vals[RI_CTRL][2];
    assign ctl_mode_o     = vals[RI_CTRL][1:0];
    assign cmp_a_o        = vals[RI_CMPA][CMP_W-1:0];
    assign cmp_b_o        = vals[RI_CMPB][CMP_W-1:0];
    assign div_sel_o      = vals[RI_DIV][DIV_W-1:0];
    assign ivl_irq_en_o   = vals[RI_IVL][15];
    assign ivl_zero_clr_o = vals[RI_IVL][0];
    assign pls_b_irq_en_o = vals[RI_PLS][15];
    assign pls_a_irq_en_o = vals[RI_PLS][14];
    assign pls_ff_init_o  = vals[RI_PLS][0];
    assign wdg_irq_en_o   = vals[RI_WDG][15];
    assign wdg_disable_o  = vals[RI_WDG][7];
    assign wdg_clear_o    = vals[RI_WDG][0];
endmodule

// File: rtl/tmr_regbank_chk.sv
// Property checker for the timer register bank, bound to the top module.
// Assumes the default 8-bit address window.
module tmr_regbank_chk #(
    parameter int ADDR_W = 8,
    parameter int CMP_W  = 24,
    parameter int STAT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic [STAT_W-1:0] stat_set_i,
    input logic [STAT_W-1:0] stat_q,
    input logic [CMP_W-1:0]  cmp_a_o,
    input logic [CMP_W-1:0]  cmp_b_o,
    input logic [1:0]        ctl_mode_o,
    input logic              ctl_run_o,
    input logic              cnt_clear_o,
    input logic              irq_clear_o
);
    logic [ADDR_W-3:0] wnum;
    logic              unmapped;
    logic              clr_wr;

    // Independent view of the address map
    always_comb begin
        wnum     = bus_addr[ADDR_W-1:2];
        unmapped = !(wnum inside {0, 1, 2, 3, 4, 8, 12, 16, 60});
        clr_wr   = bus_wr && (wnum == 1) && (bus_addr[1:0] == 2'd3);
    end

    AST_CNT_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear_o |-> $past(bus_wr && wnum == 0 && bus_addr[1:0] == 2'd3
                              && !bus_wdata[7] && bus_wdata[5])); // R4

    AST_IRQ_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear_o |-> $past(clr_wr && stat_q != '0)); // R6

    AST_STAT_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && stat_set_i == '0) |=> (stat_q == '0)); // R5

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R5

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == 32'h0)); // R12

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R13

    AST_READBACK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wnum == 60) |=> ($stable(cmp_a_o) && $stable(cmp_b_o)
                                    && $stable(ctl_mode_o) && $stable(ctl_run_o))); // R11
endmodule

bind tmr_regbank tmr_regbank_chk #(
    .ADDR_W (ADDR_W),
    .CMP_W  (CMP_W),
    .STAT_W (STAT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .stat_set_i  (stat_set_i),
    .stat_q      (stat_q),
    .cmp_a_o     (cmp_a_o),
    .cmp_b_o     (cmp_b_o),
    .ctl_mode_o  (ctl_mode_o),
    .ctl_run_o   (ctl_run_o),
    .cnt_clear_o (cnt_clear_o),
    .irq_clear_o (irq_clear_o)
);

// File: tb/tb_tmr_regbank.sv
// Sweep bench: every word, every lane, several data bytes, against a
// bit-mask model built from the requirements.
module tb_tmr_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [23:0] cnt_value = '0;
    logic [3:0]  stat_set = '0;
    logic        ctl_run_o, ctl_div_en_o, ctl_cnt_rst_o, ctl_ext_clk_o;
    logic [1:0]  ctl_mode_o;
    logic [23:0] cmp_a_o, cmp_b_o;
    logic [2:0]  div_sel_o;
    logic        ivl_irq_en_o, ivl_zero_clr_o, pls_a_irq_en_o, pls_b_irq_en_o;
    logic        pls_ff_init_o, wdg_irq_en_o, wdg_disable_o, wdg_clear_o;
    logic        cnt_clear_o, irq_clear_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_reg [64];
    logic [3:0]  exp_stat;
    logic        cc_seen, ic_seen;
    logic [31:0] rd_val;

    always #10 clk = ~clk;

    tmr_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cnt_value_i(cnt_value), .stat_set_i(stat_set),
        .ctl_run_o(ctl_run_o), .ctl_div_en_o(ctl_div_en_o),
        .ctl_cnt_rst_o(ctl_cnt_rst_o), .ctl_ext_clk_o(ctl_ext_clk_o),
        .ctl_mode_o(ctl_mode_o), .cmp_a_o(cmp_a_o), .cmp_b_o(cmp_b_o),
        .div_sel_o(div_sel_o), .ivl_irq_en_o(ivl_irq_en_o),
        .ivl_zero_clr_o(ivl_zero_clr_o), .pls_a_irq_en_o(pls_a_irq_en_o),
        .pls_b_irq_en_o(pls_b_irq_en_o), .pls_ff_init_o(pls_ff_init_o),
        .wdg_irq_en_o(wdg_irq_en_o), .wdg_disable_o(wdg_disable_o),
        .wdg_clear_o(wdg_clear_o), .cnt_clear_o(cnt_clear_o),
        .irq_clear_o(irq_clear_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Writable bits per word and byte offset, taken from the requirements
    function automatic logic [7:0] lane_mask(input int w, input int off);
        case (w)
            0:    return (off == 3) ? 8'hEF : 8'h00;
            2, 3: return (off != 0) ? 8'hFF : 8'h00;
            4:    return (off == 2) ? 8'h80 : (off == 3) ? 8'h01 : 8'h00;
            8:    return (off == 3) ? 8'h07 : 8'h00;
            12:   return (off == 2) ? 8'hC0 : (off == 3) ? 8'h01 : 8'h00;
            16:   return (off == 2) ? 8'h80 : (off == 3) ? 8'h81 : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input int w);
        case (w)
            0: return "R3";  1: return "R5";  2, 3: return "R2";
            4: return "R7";  8: return "R10"; 12: return "R8";
            16: return "R9"; 60: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input int w);
        if (w == 1)  return {28'h0, exp_stat};
        if (w == 60) return {8'h0, cnt_value};
        return exp_reg[w];
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        cc_seen = cnt_clear_o;
        ic_seen = irq_clear_o;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic check_fields(input string tag);
        logic [31:0] e0, e4, e8, e12, e16;
        e0 = exp_reg[0]; e4 = exp_reg[4]; e8 = exp_reg[8]; e12 = exp_reg[12]; e16 = exp_reg[16];
        chk({ctl_run_o, ctl_div_en_o, ctl_cnt_rst_o, ctl_ext_clk_o, ctl_mode_o} ==
            {e0[7], e0[6], e0[5], e0[2], e0[1:0]}, {tag, "/R3 ctl"},
            32'({ctl_run_o, ctl_div_en_o, ctl_cnt_rst_o, ctl_ext_clk_o, ctl_mode_o}),
            32'({e0[7], e0[6], e0[5], e0[2], e0[1:0]}));
        chk({cmp_a_o, cmp_b_o} == {exp_reg[2][23:0], exp_reg[3][23:0]}, {tag, "/R2 cmp"},
            32'(cmp_a_o ^ cmp_b_o), 32'(exp_reg[2][23:0] ^ exp_reg[3][23:0]));
        chk({div_sel_o, ivl_irq_en_o, ivl_zero_clr_o, pls_b_irq_en_o, pls_a_irq_en_o,
             pls_ff_init_o, wdg_irq_en_o, wdg_disable_o, wdg_clear_o} ==
            {e8[2:0], e4[15], e4[0], e12[15], e12[14], e12[0], e16[15], e16[7], e16[0]},
            {tag, "/R7 R8 R9 R10 fields"},
            32'({div_sel_o, ivl_irq_en_o, ivl_zero_clr_o, pls_b_irq_en_o, pls_a_irq_en_o,
                 pls_ff_init_o, wdg_irq_en_o, wdg_disable_o, wdg_clear_o}),
            32'({e8[2:0], e4[15], e4[0], e12[15], e12[14], e12[0], e16[15], e16[7], e16[0]}));
    endtask

    task automatic pulse_set(input logic [3:0] s);
        @(negedge clk);
        stat_set = s;
        @(negedge clk);
        stat_set = '0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'hFF; pats[1] = 8'hA5; pats[2] = 8'h20; pats[3] = 8'h00;
        for (int w = 0; w < 64; w++) exp_reg[w] = 32'h0;
        exp_reg[2] = 32'h00FF_FFFF;
        exp_reg[3] = 32'h00FF_FFFF;
        exp_stat = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(bus_rdata == 32'h0, "R1 rdata", bus_rdata, 32'h0);
        chk(cnt_clear_o == 1'b0 && irq_clear_o == 1'b0, "R1 strobes",
            32'({cnt_clear_o, irq_clear_o}), 32'h0);
        check_fields("R1");
        rd(8'h08, rd_val);
        chk(rd_val == 32'h00FF_FFFF, "R1 compare A reset", rd_val, 32'h00FF_FFFF);

        // Sweep every word, every byte offset, several patterns
        for (int w = 0; w < 64; w++) begin
            for (int off = 0; off < 4; off++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [7:0] d, m;
                    logic       exp_cc, exp_ic;
                    int         sh;
                    d = pats[p];
                    m = lane_mask(w, off);
                    sh = (3 - off) * 8;
                    exp_cc = (w == 0) && (off == 3) && !d[7] && d[5];
                    exp_ic = (w == 1) && (off == 3) && (exp_stat != 0);
                    cnt_value = 24'(w * 4099 + off * 257 + p * 31 + 1);
                    wr(8'(w * 4 + off), d);
                    if (w == 1 && off == 3) exp_stat = '0;
                    exp_reg[w][sh +: 8] = (exp_reg[w][sh +: 8] & ~m) | (d & m);
                    chk(cc_seen == exp_cc, "R4 counter clear strobe", 32'(cc_seen), 32'(exp_cc));
                    chk(ic_seen == exp_ic, "R6 irq clear strobe", 32'(ic_seen), 32'(exp_ic));
                    rd(8'(w * 4), rd_val);
                    chk(rd_val == exp_read(w), tag_of(w), rd_val, exp_read(w));
                    check_fields(tag_of(w));
                end
            end
        end

        // R5: set pulses are sticky and accumulate
        pulse_set(4'b0101);
        rd(8'h04, rd_val);
        chk(rd_val == 32'h5, "R5 set pulses latch", rd_val, 32'h5);
        pulse_set(4'b1000);
        rd(8'h04, rd_val);
        chk(rd_val == 32'hD, "R5 sticky accumulate", rd_val, 32'hD);

        // R5: writes to upper status bytes are ignored
        wr(8'h04, 8'h00);
        wr(8'h06, 8'hFF);
        rd(8'h04, rd_val);
        chk(rd_val == 32'hD, "R5 upper lane write ignored", rd_val, 32'hD);
        chk(ic_seen == 1'b0, "R6 no strobe on ignored lane", 32'(ic_seen), 32'h0);

        // R6: clear with pending bits strobes, clear of empty status does not
        wr(8'h07, 8'h00);
        chk(ic_seen == 1'b1, "R6 strobe on clearing pending", 32'(ic_seen), 32'h1);
        rd(8'h04, rd_val);
        chk(rd_val == 32'h0, "R5 clear write empties status", rd_val, 32'h0);
        wr(8'h07, 8'h00);
        chk(ic_seen == 1'b0, "R6 no strobe when already empty", 32'(ic_seen), 32'h0);

        // R5: set pulse in the clear cycle survives
        pulse_set(4'b0001);
        @(negedge clk);
        bus_addr = 8'h07; bus_wdata = 8'h00; bus_wr = 1'b1; stat_set = 4'b0010;
        @(negedge clk);
        bus_wr = 1'b0; stat_set = '0;
        chk(irq_clear_o == 1'b1, "R6 strobe with set in same cycle", 32'(irq_clear_o), 32'h1);
        rd(8'h04, rd_val);
        chk(rd_val == 32'h2, "R5 set wins over clear", rd_val, 32'h2);

        // R4: control write with run high and reset high gives no strobe
        wr(8'h03, 8'hA0);
        chk(cc_seen == 1'b0, "R4 no strobe when run set", 32'(cc_seen), 32'h0);
        exp_reg[0] = 32'hA0;
        check_fields("R3");

        // R13: read data holds while no read is issued
        cnt_value = 24'h13579B;
        rd(8'hF0, rd_val);
        chk(rd_val == 32'h0013_579B, "R11 live count readback", rd_val, 32'h0013_579B);
        @(negedge clk);
        bus_addr = 8'h08; cnt_value = 24'h2468AC;
        @(negedge clk);
        @(negedge clk);
        chk(bus_rdata == 32'h0013_579B, "R13 rdata holds between reads", bus_rdata, 32'h0013_579B);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule